// File: doc/BRIEF.md
# Decoder Status Flag Generator

This block drives three status pins that a host microcontroller watches while an audio decoding engine runs. A fourth output raises an alarm when the decoder stops showing signs of life. The flags are: a control-bus busy flag, which stays high until the engine can accept control messages; a heartbeat flag, which toggles at a rate set by the data being decoded; and a mute flag, which tells the host whether the audio is valid.

Two operating modes are supported, selected by `pcmMode`. In compressed mode the heartbeat toggles once for every frame synchronisation pattern that the engine reports. The mute flag follows the sync state: it clears on sync and sets again as soon as sync is lost. In PCM mode the heartbeat toggles once for every block of `PCM_BLOCK` samples (1024 by default). The mute flag then follows the engine's initialisation status. A sample counter measures the time since the last heartbeat toggle and drives the alarm. Changing the mode restarts both counters.

Top module: `decoder_flags`

## Requirements
- R1: While and right after reset, ctrlBusyFlag = 1, heartbeatFlag = 1, muteFlag = 1 and watchdogAlarm = 0.
- R2: A readyPulse drives ctrlBusyFlag to 0 in the next cycle. It stays 0 until the next reset.
- R3: In compressed mode (pcmMode = 0), every cycle with syncPulse inverts heartbeatFlag in the next cycle. sampleStrobe, syncLost and the other inputs never change heartbeatFlag in this mode.
- R4: In compressed mode, syncPulse without syncLost drives muteFlag to 0 in the next cycle. If neither syncPulse nor syncLost is present, muteFlag keeps its value.
- R5: In compressed mode, syncLost drives muteFlag to 1 in the next cycle. It takes precedence over a syncPulse in the same cycle.
- R6: In PCM mode (pcmMode = 1), muteFlag in each cycle equals the inverse of pcmInitDone from the previous cycle. syncPulse and syncLost have no effect on it.
- R7: In PCM mode, heartbeatFlag inverts in the cycle after every PCM_BLOCK-th counted sampleStrobe. syncPulse has no effect.
- R8: A cycle in which pcmMode differs from its value in the previous cycle is a mode change. In that cycle the PCM sample count and the watchdog count restart from zero, the cycle's sampleStrobe is not counted and the heartbeat does not toggle. A change into compressed mode sets muteFlag to 1.
- R9: watchdogAlarm rises in the cycle after the sampleStrobe that brings the number of samples since the last heartbeat toggle or mode change to watchdogLimit (a value of 0 disables the alarm). A heartbeat toggle or a mode change clears it. A strobe that toggles the heartbeat counts as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| readyPulse | input | 1 | Engine can accept control messages |
| syncPulse | input | 1 | Frame sync pattern detected (compressed mode) |
| syncLost | input | 1 | Frame sync lost (compressed mode) |
| pcmMode | input | 1 | 0 = compressed, 1 = PCM |
| pcmInitDone | input | 1 | PCM initialisation finished |
| sampleStrobe | input | 1 | One output sample produced |
| watchdogLimit | input | WD_W | Samples allowed between heartbeat toggles, 0 = off |
| ctrlBusyFlag | output | 1 | 1 until control bus is ready |
| heartbeatFlag | output | 1 | Toggling life signal |
| muteFlag | output | 1 | 1 = audio not valid |
| watchdogAlarm | output | 1 | Heartbeat overdue |

## Verification
On every cycle the assertions check the local cause-and-effect rules. They cover the reset values, stickiness of the ready flag, heartbeat toggling on sync in compressed mode, and heartbeat stability without a strobe in PCM mode. They also cover the precedence of sync loss, mute tracking of initialisation in PCM mode, and clearing of the alarm on every toggle. The scenarios are needed for the counted behaviour. Examples are the exact PCM_BLOCK-th strobe that toggles the heartbeat, the strobe dropped at a mode change, and the watchdog firing at each limit from 0 to 20 relative to the block length. These are checked against a cycle model in the bench, with a small block size.

// File: rtl/decflag_pkg.sv
package decflag_pkg;

  // Strobes from the control decoder to the flag/counter datapath.
  typedef struct packed {
    logic readySet;   // drop the busy flag
    logic hbToggle;   // invert heartbeat
    logic muteSet;    // force mute high
    logic muteClr;    // force mute low
    logic sampClr;    // restart PCM sample count
    logic sampInc;    // count one PCM sample
    logic wdClr;      // restart watchdog count, drop alarm
    logic wdInc;      // count one sample toward the watchdog
  } flagStrobes_t;

endpackage

// File: rtl/decflag_ctrl.sv
module decflag_ctrl
  import decflag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         readyPulse,
  input  logic         syncPulse,
  input  logic         syncLost,
  input  logic         pcmMode,
  input  logic         pcmInitDone,
  input  logic         sampleStrobe,
  input  logic         blockEnd,
  output flagStrobes_t strb
);

  logic modeQ;
  logic modeChg;
  logic toggleNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= pcmMode;
  end

  assign modeChg = pcmMode != modeQ;

  always_comb begin
    if (modeChg)      toggleNow = 1'b0;
    else if (pcmMode) toggleNow = sampleStrobe && blockEnd;
    else              toggleNow = syncPulse;
  end

  always_comb begin
    strb          = '0;
    strb.readySet = readyPulse;
    strb.hbToggle = toggleNow;
    if (pcmMode) begin
      strb.muteSet = !pcmInitDone;
      strb.muteClr = pcmInitDone;
    end else if (modeChg) begin
      strb.muteSet = 1'b1;
    end else begin
      strb.muteSet = syncLost;
      strb.muteClr = syncPulse && !syncLost;
    end
    strb.sampClr = modeChg || !pcmMode || toggleNow;
    strb.sampInc = pcmMode && sampleStrobe && !modeChg;
    strb.wdClr   = modeChg || toggleNow;
    strb.wdInc   = sampleStrobe && !(modeChg || toggleNow);
  end

endmodule

// File: rtl/decflag_dp.sv
module decflag_dp
  import decflag_pkg::*;
#(
  parameter int PCM_BLOCK = 1024,
  parameter int WD_W      = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  flagStrobes_t    strb,
  input  logic [WD_W-1:0] watchdogLimit,
  output logic            blockEnd,
  output logic            busyQ,
  output logic            hbQ,
  output logic            muteQ,
  output logic            alarmQ
);

  localparam int CNT_W = (PCM_BLOCK > 1) ? $clog2(PCM_BLOCK) : 1;
  localparam bit POW2  = (PCM_BLOCK > 1) && ((PCM_BLOCK & (PCM_BLOCK - 1)) == 0);

  logic [CNT_W-1:0] sampCnt;
  logic [WD_W-1:0]  wdCnt;
  logic [WD_W:0]    wdNext;
  logic             wdHit;

  generate
    if (POW2) begin : g_pow2
      assign blockEnd = &sampCnt;
    end else begin : g_cmp
      assign blockEnd = sampCnt == CNT_W'(PCM_BLOCK - 1);
    end
  endgenerate

  assign wdNext = {1'b0, wdCnt} + (WD_W+1)'(1);
  assign wdHit  = (watchdogLimit != '0) && (wdNext >= {1'b0, watchdogLimit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt <= '0;
    end else if (strb.sampClr) begin
      sampCnt <= '0;
    end else if (strb.sampInc) begin
      sampCnt <= sampCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt  <= '0;
      alarmQ <= 1'b0;
    end else if (strb.wdClr) begin
      wdCnt  <= '0;
      alarmQ <= 1'b0;
    end else if (strb.wdInc) begin
      if (wdCnt != '1) wdCnt <= wdNext[WD_W-1:0];
      if (wdHit) alarmQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b1;
      hbQ   <= 1'b1;
      muteQ <= 1'b1;
    end else begin
      if (strb.readySet) busyQ <= 1'b0;
      if (strb.hbToggle) hbQ   <= !hbQ;
      if (strb.muteSet)      muteQ <= 1'b1;
      else if (strb.muteClr) muteQ <= 1'b0;
    end
  end

endmodule

// File: rtl/decoder_flags.sv
module decoder_flags
  import decflag_pkg::*;
#(
  parameter int PCM_BLOCK = 1024,
  parameter int WD_W      = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            readyPulse,
  input  logic            syncPulse,
  input  logic            syncLost,
  input  logic            pcmMode,
  input  logic            pcmInitDone,
  input  logic            sampleStrobe,
  input  logic [WD_W-1:0] watchdogLimit,
  output logic            ctrlBusyFlag,
  output logic            heartbeatFlag,
  output logic            muteFlag,
  output logic            watchdogAlarm
);

  flagStrobes_t strb;
  logic         blockEnd;

  decflag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .readyPulse(readyPulse), .syncPulse(syncPulse),
    .syncLost(syncLost), .pcmMode(pcmMode), .pcmInitDone(pcmInitDone),
    .sampleStrobe(sampleStrobe), .blockEnd(blockEnd), .strb(strb)
  );

  decflag_dp #(.PCM_BLOCK(PCM_BLOCK), .WD_W(WD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .watchdogLimit(watchdogLimit),
    .blockEnd(blockEnd), .busyQ(ctrlBusyFlag), .hbQ(heartbeatFlag),
    .muteQ(muteFlag), .alarmQ(watchdogAlarm)
  );

endmodule

// File: rtl/decflag_chk.sv
module decflag_chk (
  input logic clk,
  input logic rstN,
  input logic readyPulse,
  input logic syncPulse,
  input logic syncLost,
  input logic pcmMode,
  input logic pcmInitDone,
  input logic sampleStrobe,
  input logic ctrlBusyFlag,
  input logic heartbeatFlag,
  input logic muteFlag,
  input logic watchdogAlarm
);

  p_reset_flags_r1: assert property (@(posedge clk)
    !rstN |=> (ctrlBusyFlag && heartbeatFlag && muteFlag && !watchdogAlarm));

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |=> !ctrlBusyFlag);

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBusyFlag |=> !ctrlBusyFlag);

  p_hb_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!pcmMode && !$past(pcmMode) && syncPulse) |=> (heartbeatFlag != $past(heartbeatFlag)));

  p_hb_nosync_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!pcmMode && !syncPulse) |=> $stable(heartbeatFlag));

  p_mute_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!pcmMode && !$past(pcmMode) && !syncPulse && !syncLost) |=> $stable(muteFlag));

  p_mute_lost_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pcmMode && syncLost) |=> muteFlag);

  p_mute_pcm_r6: assert property (@(posedge clk) disable iff (!rstN)
    pcmMode |=> (muteFlag == !$past(pcmInitDone)));

  p_hb_nostrobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pcmMode && !sampleStrobe) |=> $stable(heartbeatFlag));

  p_hb_modeswitch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pcmMode && !$past(pcmMode)) |=> $stable(heartbeatFlag));

  p_alarm_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (heartbeatFlag != $past(heartbeatFlag)) |-> !watchdogAlarm);

endmodule

bind decoder_flags decflag_chk u_chk (
  .clk(clk), .rstN(rstN), .readyPulse(readyPulse), .syncPulse(syncPulse),
  .syncLost(syncLost), .pcmMode(pcmMode), .pcmInitDone(pcmInitDone),
  .sampleStrobe(sampleStrobe), .ctrlBusyFlag(ctrlBusyFlag),
  .heartbeatFlag(heartbeatFlag), .muteFlag(muteFlag), .watchdogAlarm(watchdogAlarm)
);

// File: tb/sim_decoder_flags.sv
`timescale 1ns/1ps
module sim_decoder_flags;

  localparam int BLK  = 16;
  localparam int WD_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readyPulse = 1'b0, syncPulse = 1'b0, syncLost = 1'b0;
  logic pcmMode = 1'b0, pcmInitDone = 1'b0, sampleStrobe = 1'b0;
  logic [WD_W-1:0] watchdogLimit = '0;
  logic ctrlBusyFlag, heartbeatFlag, muteFlag, watchdogAlarm;

  always #4 clk = ~clk;

  decoder_flags #(.PCM_BLOCK(BLK), .WD_W(WD_W)) u0 (
    .clk(clk), .rstN(rstN), .readyPulse(readyPulse), .syncPulse(syncPulse),
    .syncLost(syncLost), .pcmMode(pcmMode), .pcmInitDone(pcmInitDone),
    .sampleStrobe(sampleStrobe), .watchdogLimit(watchdogLimit),
    .ctrlBusyFlag(ctrlBusyFlag), .heartbeatFlag(heartbeatFlag),
    .muteFlag(muteFlag), .watchdogAlarm(watchdogAlarm)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Expected state, derived from the requirements.
  logic eBusy = 1'b1, eHb = 1'b1, eMute = 1'b1, eAlarm = 1'b0, eMode = 1'b0;
  int   eCnt = 0, eWd = 0;

  task automatic chk(string tag, string name, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic chkAll(string tag);
    chk(tag, "ctrlBusyFlag",  ctrlBusyFlag,  eBusy);
    chk(tag, "heartbeatFlag", heartbeatFlag, eHb);
    chk(tag, "muteFlag",      muteFlag,      eMute);
    chk(tag, "watchdogAlarm", watchdogAlarm, eAlarm);
  endtask

  // One clock: update the model from the applied inputs, then compare.
  task automatic cyc(string tag);
    logic chg, tog;
    chg = pcmMode != eMode;
    tog = !chg && (pcmMode ? (sampleStrobe && eCnt == BLK - 1) : syncPulse);
    if (readyPulse) eBusy = 1'b0;
    if (tog) eHb = !eHb;
    if (pcmMode)       eMute = !pcmInitDone;
    else if (chg)      eMute = 1'b1;
    else if (syncLost) eMute = 1'b1;
    else if (syncPulse) eMute = 1'b0;
    if (chg || !pcmMode || tog) eCnt = 0;
    else if (sampleStrobe)      eCnt = eCnt + 1;
    if (chg || tog) begin
      eWd = 0; eAlarm = 1'b0;
    end else if (sampleStrobe) begin
      if (watchdogLimit != 0 && eWd + 1 >= int'(watchdogLimit)) eAlarm = 1'b1;
      if (eWd < (1 << WD_W) - 1) eWd = eWd + 1;
    end
    eMode = pcmMode;
    @(posedge clk);
    #1;
    chkAll(tag);
    readyPulse = 1'b0; syncPulse = 1'b0; syncLost = 1'b0; sampleStrobe = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired at %0t", $time);
    report();
  end

  initial begin
    // R1: reset values
    repeat (2) @(posedge clk);
    #1;
    chkAll("R1");
    rstN = 1'b1;
    repeat (3) cyc("R1");

    // R2: ready flag falls and stays
    readyPulse = 1'b1;
    cyc("R2");
    repeat (6) cyc("R2");

    // R3/R4/R5: compressed mode, sync and loss patterns with samples ignored
    for (int i = 0; i < 60; i++) begin
      syncPulse    = (i % 3 == 0);
      syncLost     = (i % 7 == 6);
      sampleStrobe = (i % 2 == 0);
      cyc(syncLost ? "R5" : (syncPulse ? "R3/R4" : "R4"));
    end

    // R6/R8: enter PCM with init pending
    pcmMode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sampleStrobe = (i % 2 == 1);
      syncPulse    = (i % 3 == 0);
      cyc("R6/R8");
    end

    // R6/R7: PCM blocks with gaps, sync inputs ignored
    pcmInitDone = 1'b1;
    for (int i = 0; i < BLK * 5 + 7; i++) begin
      pcmInitDone  = !(i >= 30 && i < 33);
      sampleStrobe = (i % 4 != 3);
      syncPulse    = (i % 5 == 0);
      syncLost     = (i % 9 == 0);
      cyc("R6/R7");
    end

    // R8: mode switches mid-block, strobe on the switch cycle dropped
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 5 + k; i++) begin
        sampleStrobe = 1'b1;
        cyc("R8");
      end
      pcmMode = 1'b0; sampleStrobe = 1'b1; syncPulse = (k == 1);
      cyc("R8");
      syncPulse = 1'b1;
      cyc("R8");
      pcmMode = 1'b1; sampleStrobe = 1'b1;
      cyc("R8");
      for (int i = 0; i < BLK + 2; i++) begin
        sampleStrobe = 1'b1;
        cyc("R7/R8");
      end
    end

    // R9: sweep watchdog limits in PCM mode
    for (int lim = 0; lim <= 20; lim++) begin
      watchdogLimit = WD_W'(lim);
      pcmMode = 1'b0;
      cyc("R9");
      pcmMode = 1'b1;
      cyc("R9");
      for (int i = 0; i < 2 * BLK + 5; i++) begin
        sampleStrobe = (i % 6 != 5);
        cyc("R9");
      end
    end

    // R9: watchdog in compressed mode, cleared by a sync toggle
    watchdogLimit = WD_W'(5);
    pcmMode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      sampleStrobe = 1'b1;
      syncPulse    = (i == 8);
      cyc("R9");
    end

    report();
  end

endmodule